// File: doc/BRIEF.md
# Cross-Trigger Routing Matrix

This block carries debug trigger events from one part of a chip to another. Trigger inputs never reach trigger outputs directly. Each input is enabled onto any of a small number of broadcast channels, and each output is driven by any channel it is enabled from. An event on input n therefore fires output m when the two enable masks share at least one channel bit. A fired output stays high until software acknowledges it, so it can serve as an interrupt request.

The block has a simple word-addressed register port. Through it, software sets a global enable, raises channels by hand (persistent set, clear, or a one-cycle pulse), acknowledges outputs and reads status. Every register write goes through a key lock. The lock has two named states, LOCKED and OPEN:
- LOCKED moves to OPEN on the UNLOCK transition, which is a key write to the lock-access register.
- OPEN moves to LOCKED on the RELOCK transition, which is a write of any other value there.

Each trigger output has its own tracker with two named states, IDLE and FIRED:
- IDLE moves to FIRED on CAPTURE, when a routed hit arrives and no acknowledge for that output falls in the same cycle.
- FIRED moves to IDLE on ACK_CLEAR.

Top module: `ctm_matrix`

## Requirements
- R1: After reset the lock is in LOCKED, the global enable, every input-enable mask, every output-enable mask and the persistent channel set all read 0, and `trig_out` is 0.
- R2: Writing 32'hC5ACCE55 to offset 0xFB0 unlocks the block. Writing any other value there locks it. The word at 0xFB4 reads bit 1 = 1 when locked and 0 when unlocked, and bit 0 always reads 1.
- R3: While locked, writes to every offset other than 0xFB0 are ignored: register readback is unchanged, acknowledge writes leave outputs set, and pulse writes raise no channel.
- R4: The input-enable mask of input n sits at 0x020 + 4n and the output-enable mask of output m sits at 0x0A0 + 4m. Bit c means channel c. Each reads back exactly the 4 channel bits written, and its upper bits read 0.
- R5: With the block enabled, a high `trig_in[n]` sets `trig_out[m]` at the next clock edge exactly when the two masks share a channel bit. Otherwise the output stays low.
- R6: A set output holds after its input falls. Writing 1 to bit m at 0x010 clears output m alone, and bits written 0 leave their outputs untouched.
- R7: When an acknowledge and a hit for the same output fall in one cycle, the output is low after that edge and is set again at the next edge if the hit persists.
- R8: Bit 0 at 0x000 is the global enable. While it is 0, `trig_out` reads 0, channel outputs read 0 and no new capture happens. An output captured before the disable shows again when the enable returns.
- R9: A write to 0x014 ORs its low 4 bits into a persistent channel set that reads back at 0x014. A write to 0x018 clears the set bits written as 1. Set channels route to outputs exactly as input-driven channels do.
- R10: A write to 0x01C drives the written channels for exactly the one cycle after the write. Outputs fed by those channels set one edge after that.
- R11: Status words read as follows: 0x130 gives the raw trigger inputs, 0x134 gives `trig_out`, 0x138 gives channels driven by trigger inputs (regardless of the enable), and 0x13C gives the gated channel outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 12 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| trig_in | input | 8 | Trigger event inputs, level |
| trig_out | output | 8 | Latched trigger outputs |

## Verification
Two things can meet on one output tracker in the same cycle: a software acknowledge and a fresh routed hit. The bench provokes this by holding a routed input high so that the output is set and keeps seeing a hit, and then writing the acknowledge. Two things are judged from the output pin. First, the output must read low one cycle after the write, which shows the acknowledge won. Second, the output must read high again one cycle later, which shows that the persistent hit was not lost. A second collision, a disable write landing on an already-set output, is judged the same way: the output is masked at once and reappears on re-enable.

// File: rtl/ctm_pkg.sv
`timescale 1ns/1ps
package ctm_pkg;

    // Byte offsets of the register window
    localparam logic [11:0] OFS_CTRL   = 12'h000;
    localparam logic [11:0] OFS_ACK    = 12'h010;
    localparam logic [11:0] OFS_APSET  = 12'h014;
    localparam logic [11:0] OFS_APCLR  = 12'h018;
    localparam logic [11:0] OFS_APPUL  = 12'h01C;
    localparam logic [11:0] OFS_INEN   = 12'h020;
    localparam logic [11:0] OFS_OUTEN  = 12'h0A0;
    localparam logic [11:0] OFS_ST_TIN = 12'h130;
    localparam logic [11:0] OFS_ST_TOUT= 12'h134;
    localparam logic [11:0] OFS_ST_CIN = 12'h138;
    localparam logic [11:0] OFS_ST_COUT= 12'h13C;
    localparam logic [11:0] OFS_LOCK   = 12'hFB0;
    localparam logic [11:0] OFS_LSTAT  = 12'hFB4;

    localparam logic [31:0] UNLOCK_KEY = 32'hC5AC_CE55;

    typedef enum logic {
        LK_LOCKED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_state_e;

    typedef enum logic {
        OL_IDLE  = 1'b0,
        OL_FIRED = 1'b1
    } latch_state_e;

endpackage

// File: rtl/ctm_lock.sv
`timescale 1ns/1ps
module ctm_lock
    import ctm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [11:0] addr,
    input  logic [31:0] wdata,
    output logic        locked
);

    lock_state_e state_q, state_d;
    logic        lock_wr;

    assign lock_wr = wr && (addr == OFS_LOCK);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    // Next state: UNLOCK and RELOCK transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: if (lock_wr && wdata == UNLOCK_KEY) state_d = LK_OPEN;
            LK_OPEN:   if (lock_wr && wdata != UNLOCK_KEY) state_d = LK_LOCKED;
            default:   state_d = LK_LOCKED;
        endcase
    end

    // Outputs
    always_comb begin
        locked = (state_q != LK_OPEN);
    end

    assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFS_LOCK && wdata == UNLOCK_KEY) |=> !locked);

    assert_wrong_key_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFS_LOCK && wdata != UNLOCK_KEY) |=> locked);

endmodule

// File: rtl/ctm_regs.sv
`timescale 1ns/1ps
module ctm_regs
    import ctm_pkg::*;
#(
    parameter int N_IN  = 8,
    parameter int N_OUT = 8,
    parameter int N_CH  = 4,
    parameter int DW    = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr,
    input  logic [11:0]                    addr,
    input  logic [DW-1:0]                  wdata,
    input  logic                           locked,
    input  logic [N_IN-1:0]                st_trig_in,
    input  logic [N_OUT-1:0]               st_trig_out,
    input  logic [N_CH-1:0]                st_chan_in,
    input  logic [N_CH-1:0]                st_chan_out,
    output logic                           glb_en,
    output logic [N_IN-1:0][N_CH-1:0]      inen,
    output logic [N_OUT-1:0][N_CH-1:0]     outen,
    output logic [N_CH-1:0]                app_set,
    output logic [N_CH-1:0]                app_pulse,
    output logic [N_OUT-1:0]               ack,
    output logic [31:0]                    rdata
);

    logic                       wr_ok;
    logic                       en_q;
    logic [N_IN-1:0][N_CH-1:0]  inen_q;
    logic [N_OUT-1:0][N_CH-1:0] outen_q;
    logic [N_CH-1:0]            app_set_q;
    logic [N_CH-1:0]            pulse_q;
    logic                       pulse_wr;

    assign wr_ok    = wr && !locked;
    assign pulse_wr = wr_ok && (addr == OFS_APPUL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else if (wr_ok && addr == OFS_CTRL) en_q <= wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inen_q <= '0;
        end else begin
            for (int i = 0; i < N_IN; i++) begin
                if (wr_ok && addr == OFS_INEN + 12'(4*i)) inen_q[i] <= wdata[N_CH-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outen_q <= '0;
        end else begin
            for (int i = 0; i < N_OUT; i++) begin
                if (wr_ok && addr == OFS_OUTEN + 12'(4*i)) outen_q[i] <= wdata[N_CH-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) app_set_q <= '0;
        else if (wr_ok && addr == OFS_APSET) app_set_q <= app_set_q | wdata[N_CH-1:0];
        else if (wr_ok && addr == OFS_APCLR) app_set_q <= app_set_q & ~wdata[N_CH-1:0];
    end

    // One-cycle channel pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pulse_q <= '0;
        else if (pulse_wr) pulse_q <= wdata[N_CH-1:0];
        else               pulse_q <= '0;
    end

    assign ack       = (wr_ok && addr == OFS_ACK) ? wdata[N_OUT-1:0] : '0;
    assign glb_en    = en_q;
    assign inen      = inen_q;
    assign outen     = outen_q;
    assign app_set   = app_set_q;
    assign app_pulse = pulse_q;

    // Read mux
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CTRL:    rdata[0]        = en_q;
            OFS_APSET:   rdata[N_CH-1:0] = app_set_q;
            OFS_ST_TIN:  rdata[N_IN-1:0] = st_trig_in;
            OFS_ST_TOUT: rdata[N_OUT-1:0]= st_trig_out;
            OFS_ST_CIN:  rdata[N_CH-1:0] = st_chan_in;
            OFS_ST_COUT: rdata[N_CH-1:0] = st_chan_out;
            OFS_LSTAT:   rdata[1:0]      = {locked, 1'b1};
            default:     rdata           = '0;
        endcase
        for (int i = 0; i < N_IN; i++) begin
            if (addr == OFS_INEN + 12'(4*i)) rdata[N_CH-1:0] = inen_q[i];
        end
        for (int i = 0; i < N_OUT; i++) begin
            if (addr == OFS_OUTEN + 12'(4*i)) rdata[N_CH-1:0] = outen_q[i];
        end
    end

    assert_locked_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && locked && addr != OFS_LOCK) |=>
            ($stable(en_q) && $stable(inen_q) && $stable(outen_q) && $stable(app_set_q) && pulse_q == '0));

    assert_pulse_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_q != '0 && !pulse_wr) |=> (pulse_q == '0));

endmodule

// File: rtl/ctm_outlatch.sv
`timescale 1ns/1ps
module ctm_outlatch
    import ctm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic ack,
    output logic fired
);

    latch_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OL_IDLE;
        else        state_q <= state_d;
    end

    // CAPTURE and ACK_CLEAR transitions; acknowledge wins a tie
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OL_IDLE:  if (hit && !ack) state_d = OL_FIRED;
            OL_FIRED: if (ack)         state_d = OL_IDLE;
            default:  state_d = OL_IDLE;
        endcase
    end

    always_comb begin
        fired = (state_q == OL_FIRED);
    end

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !fired);

    assert_hit_captures_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !ack) |=> fired);

endmodule

// File: rtl/ctm_route.sv
`timescale 1ns/1ps
module ctm_route #(
    parameter int N_IN  = 8,
    parameter int N_OUT = 8,
    parameter int N_CH  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_IN-1:0]            trig_in,
    input  logic [N_IN-1:0][N_CH-1:0]  inen,
    input  logic [N_OUT-1:0][N_CH-1:0] outen,
    input  logic [N_CH-1:0]            app_set,
    input  logic [N_CH-1:0]            app_pulse,
    input  logic                       glb_en,
    input  logic [N_OUT-1:0]           ack,
    output logic [N_CH-1:0]            chan_in,
    output logic [N_CH-1:0]            chan_out,
    output logic [N_OUT-1:0]           trig_out
);

    logic [N_OUT-1:0] hit;
    logic [N_OUT-1:0] fired;

    // Gather inputs onto channels
    always_comb begin
        chan_in = '0;
        for (int c = 0; c < N_CH; c++) begin
            for (int n = 0; n < N_IN; n++) begin
                chan_in[c] = chan_in[c] | (trig_in[n] & inen[n][c]);
            end
        end
    end

    assign chan_out = glb_en ? (chan_in | app_set | app_pulse) : '0;

    // Fan channels out to outputs
    always_comb begin
        for (int m = 0; m < N_OUT; m++) begin
            hit[m] = |(chan_out & outen[m]);
        end
    end

    for (genvar m = 0; m < N_OUT; m++) begin : g_out
        ctm_outlatch u_latch (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit[m]),
            .ack   (ack[m]),
            .fired (fired[m])
        );
    end

    assign trig_out = glb_en ? fired : '0;

    assert_disabled_no_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en && fired == '0) |=> (fired == '0));

endmodule

// File: rtl/ctm_matrix.sv
`timescale 1ns/1ps
module ctm_matrix #(
    parameter int N_TRIG_IN  = 8,
    parameter int N_TRIG_OUT = 8,
    parameter int N_CHAN     = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [11:0]           reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic [N_TRIG_IN-1:0]  trig_in,
    output logic [N_TRIG_OUT-1:0] trig_out
);

    localparam int DW = (N_TRIG_OUT > N_CHAN) ? N_TRIG_OUT : N_CHAN;

    logic                             locked;
    logic                             glb_en;
    logic [N_TRIG_IN-1:0][N_CHAN-1:0] inen;
    logic [N_TRIG_OUT-1:0][N_CHAN-1:0] outen;
    logic [N_CHAN-1:0]                app_set;
    logic [N_CHAN-1:0]                app_pulse;
    logic [N_TRIG_OUT-1:0]            ack;
    logic [N_CHAN-1:0]                chan_in;
    logic [N_CHAN-1:0]                chan_out;

    ctm_lock u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .locked (locked)
    );

    ctm_regs #(
        .N_IN  (N_TRIG_IN),
        .N_OUT (N_TRIG_OUT),
        .N_CH  (N_CHAN),
        .DW    (DW)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (reg_wr),
        .addr        (reg_addr),
        .wdata       (reg_wdata[DW-1:0]),
        .locked      (locked),
        .st_trig_in  (trig_in),
        .st_trig_out (trig_out),
        .st_chan_in  (chan_in),
        .st_chan_out (chan_out),
        .glb_en      (glb_en),
        .inen        (inen),
        .outen       (outen),
        .app_set     (app_set),
        .app_pulse   (app_pulse),
        .ack         (ack),
        .rdata       (reg_rdata)
    );

    ctm_route #(
        .N_IN  (N_TRIG_IN),
        .N_OUT (N_TRIG_OUT),
        .N_CH  (N_CHAN)
    ) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_in   (trig_in),
        .inen      (inen),
        .outen     (outen),
        .app_set   (app_set),
        .app_pulse (app_pulse),
        .glb_en    (glb_en),
        .ack       (ack),
        .chan_in   (chan_in),
        .chan_out  (chan_out),
        .trig_out  (trig_out)
    );

endmodule

// File: tb/tb_ctm_matrix.sv
`timescale 1ns/1ps
module tb_ctm_matrix;

    localparam logic [11:0] A_CTRL = 12'h000, A_ACK = 12'h010, A_SET = 12'h014,
                            A_CLR = 12'h018, A_PUL = 12'h01C, A_IN = 12'h020,
                            A_OUT = 12'h0A0, A_TIN = 12'h130, A_TOUT = 12'h134,
                            A_CIN = 12'h138, A_COUT = 12'h13C, A_LAR = 12'hFB0,
                            A_LSR = 12'hFB4;
    localparam logic [31:0] KEY = 32'hC5ACCE55;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  trig_in = '0;
    logic [7:0]  trig_out;

    int nvec = 0;
    int nbad = 0;

    always #2 clk = ~clk;

    ctm_matrix dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .trig_in   (trig_in),
        .trig_out  (trig_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.1;
        d = reg_rdata;
        @(negedge clk);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual running expected done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 trig_out", {24'b0, trig_out}, 32'h0);
        rd(A_LSR, d);  chk("R1 lock status", d, 32'h3);
        rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
        rd(A_IN, d);   chk("R1 in mask 0", d, 32'h0);
        rd(A_OUT + 12'd28, d); chk("R1 out mask 7", d, 32'h0);
        rd(A_SET, d);  chk("R1 app set", d, 32'h0);

        // R3 writes while locked are dropped
        wr(A_CTRL, 32'h1); wr(A_IN, 32'hF); wr(A_OUT, 32'hF); wr(A_SET, 32'hF);
        rd(A_CTRL, d); chk("R3 ctrl locked", d, 32'h0);
        rd(A_IN, d);   chk("R3 in mask locked", d, 32'h0);
        rd(A_SET, d);  chk("R3 app set locked", d, 32'h0);
        trig_in = 8'h01; @(negedge clk);
        chk("R3 no route locked", {24'b0, trig_out}, 32'h0);
        trig_in = 8'h00;

        // R2 key sweep: every single-bit error relocks
        wr(A_LAR, KEY); rd(A_LSR, d); chk("R2 unlocked status", d, 32'h1);
        for (int b = 0; b < 32; b++) begin
            wr(A_LAR, KEY);
            wr(A_LAR, KEY ^ (32'h1 << b));
            rd(A_LSR, d); chk("R2 wrong key relocks", d, 32'h3);
        end
        wr(A_LAR, KEY);

        // R4 readback sweep with junk in upper bits
        for (int i = 0; i < 8; i++) begin
            for (int v = 0; v < 16; v++) begin
                wr(A_IN + 12'(4*i), 32'hDEAD_BEE0 | 32'(v));
                rd(A_IN + 12'(4*i), d); chk("R4 in mask readback", d, 32'(v));
                wr(A_OUT + 12'(4*i), 32'h5A5A_5A50 | 32'(15 - v));
                rd(A_OUT + 12'(4*i), d); chk("R4 out mask readback", d, 32'(15 - v));
            end
            wr(A_IN + 12'(4*i), 32'h0);
            wr(A_OUT + 12'(4*i), 32'h0);
        end

        wr(A_CTRL, 32'h1);
        rd(A_CTRL, d); chk("R8 ctrl readback", d, 32'h1);

        // R5 routing sweep over input, masks; R11 channel-in status
        for (int n = 0; n < 8; n++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    int m;
                    m = (n + a + b) % 8;
                    wr(A_IN + 12'(4*n), 32'(a));
                    wr(A_OUT + 12'(4*m), 32'(b));
                    wr(A_ACK, 32'hFF);
                    trig_in = 8'(1 << n);
                    rd(A_CIN, d); chk("R11 chan in status", d, 32'(a));
                    chk("R5 route", {24'b0, trig_out}, ((a & b) != 0) ? 32'(1 << m) : 32'h0);
                    trig_in = 8'h00;
                    wr(A_IN + 12'(4*n), 32'h0);
                    wr(A_OUT + 12'(4*m), 32'h0);
                end
            end
        end
        wr(A_ACK, 32'hFF);

        // R6 hold and selective acknowledge
        wr(A_IN + 12'd8, 32'h1);
        wr(A_OUT + 12'd20, 32'h1);
        wr(A_OUT + 12'd24, 32'h1);
        trig_in = 8'h04; @(negedge clk); trig_in = 8'h00;
        chk("R6 set", {24'b0, trig_out}, 32'h60);
        repeat (3) @(negedge clk);
        chk("R6 hold", {24'b0, trig_out}, 32'h60);
        wr(A_ACK, 32'h20); chk("R6 ack bit5 only", {24'b0, trig_out}, 32'h40);
        wr(A_ACK, 32'h40); chk("R6 ack bit6", {24'b0, trig_out}, 32'h0);

        // R7 acknowledge collides with a held hit
        trig_in = 8'h04; @(negedge clk);
        chk("R7 pre", {24'b0, trig_out}, 32'h60);
        wr(A_ACK, 32'h60);
        chk("R7 ack wins", {24'b0, trig_out}, 32'h0);
        @(negedge clk);
        chk("R7 recapture", {24'b0, trig_out}, 32'h60);
        rd(A_TOUT, d); chk("R11 trig out status", d, 32'h60);
        rd(A_TIN, d);  chk("R11 trig in status", d, 32'h04);
        rd(A_COUT, d); chk("R11 chan out status", d, 32'h1);

        // R8 disable masks, blocks capture, reveals on re-enable
        wr(A_CTRL, 32'h0);
        chk("R8 masked", {24'b0, trig_out}, 32'h0);
        rd(A_COUT, d); chk("R8 chan out gated", d, 32'h0);
        rd(A_CIN, d);  chk("R11 chan in raw when off", d, 32'h1);
        wr(A_ACK, 32'hFF);
        @(negedge clk); trig_in = 8'h00;
        wr(A_CTRL, 32'h1);
        chk("R8 no capture while off", {24'b0, trig_out}, 32'h0);
        trig_in = 8'h04; @(negedge clk); trig_in = 8'h00;
        wr(A_CTRL, 32'h0); chk("R8 mask set output", {24'b0, trig_out}, 32'h0);
        wr(A_CTRL, 32'h1); chk("R8 reappear", {24'b0, trig_out}, 32'h60);
        wr(A_ACK, 32'hFF);

        // R9 persistent set and clear
        wr(A_OUT + 12'd20, 32'h2);
        wr(A_SET, 32'h2); @(negedge clk);
        chk("R9 set routes", {24'b0, trig_out}, 32'h20);
        rd(A_SET, d); chk("R9 set readback", d, 32'h2);
        wr(A_SET, 32'h8);
        rd(A_SET, d); chk("R9 set ORs", d, 32'hA);
        wr(A_CLR, 32'h2);
        rd(A_SET, d); chk("R9 clear", d, 32'h8);
        wr(A_ACK, 32'hFF); @(negedge clk);
        chk("R9 cleared channel idle", {24'b0, trig_out}, 32'h0);
        rd(A_COUT, d); chk("R9 remaining channel", d, 32'h8);
        wr(A_CLR, 32'hF);

        // R10 one-cycle pulse
        wr(A_PUL, 32'h1);
        rd(A_COUT, d); chk("R10 pulse visible", d, 32'h1);
        chk("R10 pulse captured", {24'b0, trig_out}, 32'h40);
        rd(A_COUT, d); chk("R10 pulse gone", d, 32'h0);
        wr(A_ACK, 32'h40); @(negedge clk);
        chk("R10 no second cycle", {24'b0, trig_out}, 32'h0);

        // R3 acknowledge and pulse while locked
        wr(A_PUL, 32'h1); @(negedge clk);
        chk("R3 setup", {24'b0, trig_out}, 32'h40);
        wr(A_LAR, 32'h0);
        wr(A_ACK, 32'hFF);
        chk("R3 ack dropped", {24'b0, trig_out}, 32'h40);
        wr(A_PUL, 32'h2); @(negedge clk);
        chk("R3 pulse dropped", {24'b0, trig_out}, 32'h40);
        wr(A_LAR, KEY);
        wr(A_ACK, 32'hFF);
        chk("R3 ack after unlock", {24'b0, trig_out}, 32'h0);

        summary();
        $finish;
    end

endmodule